// File: doc/BRIEF.md
# RGB565 Camera Byte Pair Packer

This block sits in the pixel-clock domain right behind a parallel camera port. The port carries one byte per clock, qualified by a line-valid level and framed by a vertical sync level. Each 16-bit RGB565 pixel arrives as two bytes on consecutive clocks, high byte first. The block rebuilds the pixel from each pair and collects a parameter-set number of pixels into one wide word of 32 or 64 bits. It raises a one-clock write strobe for that word so that a write FIFO can take it.

A line that ends part of the way through a word is flushed as a word whose unused pixel slots are zero. A byte left without its partner when the line ends is dropped. Capture is held off after reset until one complete sync pulse has been seen, so the block never delivers the tail of a frame it joined part of the way through. A one-clock frame-start pulse marks the close of every sync pulse, so that a downstream frame buffer can rewind its address.

Top module: `dvp_rgb565_packer`

## Requirements
- R1: The inputs are sampled on the rising clock edge. On a line, the first byte of each pair becomes pixel bits 15:8 and the second byte becomes bits 7:0.
- R2: Pixel k of a word (k counted from 0 within the word) occupies word bits 16k+15 down to 16k. The first pixel of the word therefore lands in bits 15:0.
- R3: When the last pixel slot of a word fills, `word_we` is high for exactly one clock, starting the clock after the edge that sampled the closing byte, and `word_data` carries that word.
- R4: Bytes presented while `cam_href` is low do not reach any output word.
- R5: When `cam_href` falls with one or more pixels waiting, those pixels are written as one word, with all unfilled slots zero, in the clock after the edge that sampled `cam_href` low. A lone first byte pending at the line end is discarded.
- R6: Each new line starts with a high byte and with pixel slot 0, whatever the previous line left behind.
- R7: While `cam_vsync` is high, bytes are ignored even with `cam_href` high. Pixels waiting when `cam_vsync` rises are flushed as in R5.
- R8: After reset, nothing is captured until `cam_vsync` has been sampled rising and then falling. A `cam_vsync` already high when reset is released does not count as a rise.
- R9: `frame_start` is high for one clock, in the clock after the edge that sampled a high-to-low change of `cam_vsync`, once a rise has been seen since reset. Capture begins on the edge after that one.
- R10: Reset, active low and synchronous, clears `word_data`, `word_we` and `frame_start` to zero. `word_data` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cam_data | input | 8 | Upper eight bits of the camera data bus |
| cam_href | input | 1 | Line valid, active high |
| cam_vsync | input | 1 | Vertical sync, active high |
| word_data | output | WORD_W | Packed pixels, first pixel in the least significant 16 bits |
| word_we | output | 1 | One-clock write strobe for `word_data` |
| frame_start | output | 1 | One-clock pulse at the end of each sync pulse |

## Verification
The bench aims at the edges of a line. It runs lines whose pixel count is not a multiple of the word size, lines with an odd byte count, and a sync pulse that starts while a line is still open. A design that fails to flush loses the end of the line. A design that does not clear its slots pads the flushed word with stale pixels. A design that keeps its byte phase across lines swaps the high and low bytes of every pixel on the next line. The bench also releases reset with sync already high and sends a line before any full pulse, which catches a design that arms on a sync level instead of on a complete pulse. Random frames then compare every clock against a queue-based model.

// File: rtl/dvp_pack_pkg.sv
// Shared widths and types for the camera byte-pair packer.
package dvp_pack_pkg;
    localparam int BYTE_W = 8;
    localparam int PIX_W  = 16;
    typedef logic [BYTE_W-1:0] cam_byte_t;
    typedef logic [PIX_W-1:0]  pix_t;
endpackage

// File: rtl/dvp_frame_sync.sv
// Frame sync tracker.
// Watches the vertical sync level. It marks the first rise after reset and
// pulses frame_start at each falling edge once a rise has been seen. It arms
// capture from that first pulse on.
// Assumes: vsync is already in the pclk domain; a level that is high when
// reset is released is not taken as a rise.
module dvp_frame_sync (
    input  logic pclk,
    input  logic rst_n,
    input  logic vsync,
    output logic armed,
    output logic frame_start
);
    logic vs_q;
    logic rise_seen;
    logic vs_fall;

    // Falling edge of sync, valid only after a rise has been seen.
    assign vs_fall = !vsync && vs_q && rise_seen;

    // Edge history, arming flag and the frame-start pulse.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            vs_q        <= 1'b1;
            rise_seen   <= 1'b0;
            armed       <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            vs_q        <= vsync;
            frame_start <= vs_fall;
            if (vsync && !vs_q) begin
                rise_seen <= 1'b1;
            end
            if (vs_fall) begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dvp_byte_pairer.sv
// Byte pairer.
// Keeps the first byte of each pair and presents a 16-bit pixel, high byte
// first, in the clock that the second byte arrives.
// Assumes: take is high only for bytes that belong to an open line; the
// phase restarts on every clock where take is low.
module dvp_byte_pairer
    import dvp_pack_pkg::*;
(
    input  logic      pclk,
    input  logic      rst_n,
    input  logic      take,
    input  cam_byte_t data,
    output logic      pix_valid,
    output pix_t      pix
);
    logic      phase;
    cam_byte_t hi_q;

    // Byte phase toggles per accepted byte; the high byte is held.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            hi_q  <= '0;
        end else if (!take) begin
            phase <= 1'b0;
        end else begin
            if (!phase) begin
                hi_q <= data;
            end
            phase <= !phase;
        end
    end

    // Pixel is complete on the second byte of a pair.
    always_comb begin
        pix_valid = take && phase;
        pix       = {hi_q, data};
    end
endmodule

// File: rtl/dvp_pixel_gatherer.sv
// Pixel gatherer.
// Collects PIX_PER_WORD pixels into one word, the first at the bottom. It
// writes the word when the last slot fills. When the line closes with pixels
// still waiting, it flushes them with the empty slots zeroed.
// Assumes: PIX_PER_WORD is a power of two and at least 2.
module dvp_pixel_gatherer
    import dvp_pack_pkg::*;
#(
    parameter int PIX_PER_WORD = 2,
    localparam int WORD_W = PIX_PER_WORD * PIX_W,
    localparam int IDX_W  = $clog2(PIX_PER_WORD)
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              line_open,
    input  logic              pix_valid,
    input  pix_t              pix,
    output logic [WORD_W-1:0] word_data,
    output logic              word_we
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_WORD - 1);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] next_word;
    logic              emit_full;
    logic              emit_flush;
    logic              emit;

    // Word closes on a full set of slots or on a line end with pixels waiting.
    always_comb begin
        emit_full  = pix_valid && (idx == LAST_IDX);
        emit_flush = !line_open && (idx != '0);
        emit       = emit_full || emit_flush;
    end

    // One storage slot per pixel position; the word view merges the pixel arriving now.
    for (genvar i = 0; i < PIX_PER_WORD; i++) begin : g_slot
        pix_t slot_q;
        logic hit;

        assign hit = pix_valid && (idx == IDX_W'(i));
        assign next_word[i*PIX_W +: PIX_W] = hit ? pix : slot_q;

        // Slot loads its pixel and is zeroed once its word leaves or the line ends.
        always_ff @(posedge pclk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (emit || !line_open) begin
                slot_q <= '0;
            end else if (hit) begin
                slot_q <= pix;
            end
        end
    end

    // Slot index advances per pixel and restarts with every word or line end.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (emit || !line_open) begin
            idx <= '0;
        end else if (pix_valid) begin
            idx <= idx + 1'b1;
        end
    end

    // Output word register and its one-clock strobe.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            word_data <= '0;
            word_we   <= 1'b0;
        end else begin
            word_we <= emit;
            if (emit) begin
                word_data <= next_word;
            end
        end
    end
endmodule

// File: rtl/dvp_rgb565_packer.sv
// RGB565 camera byte-pair packer, top level.
// Rebuilds 16-bit pixels from byte pairs on a parallel camera port and packs
// them into WORD_W-bit words for a write FIFO. Emits a frame-start pulse at
// the end of each sync pulse.
// Assumes: all inputs are synchronous to pclk; WORD_W is 32 or 64.
module dvp_rgb565_packer
    import dvp_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int PIX_PER_WORD = WORD_W / PIX_W
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic [7:0]        cam_data,
    input  logic              cam_href,
    input  logic              cam_vsync,
    output logic [WORD_W-1:0] word_data,
    output logic              word_we,
    output logic              frame_start
);
    logic armed;
    logic line_open;
    logic pix_valid;
    pix_t pix;

    // A byte counts only on an armed, open line outside sync.
    assign line_open = armed && cam_href && !cam_vsync;

    dvp_frame_sync u_sync (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .vsync       (cam_vsync),
        .armed       (armed),
        .frame_start (frame_start)
    );

    dvp_byte_pairer u_pair (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .take      (line_open),
        .data      (cam_data),
        .pix_valid (pix_valid),
        .pix       (pix)
    );

    dvp_pixel_gatherer #(
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_gather (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .line_open (line_open),
        .pix_valid (pix_valid),
        .pix       (pix),
        .word_data (word_data),
        .word_we   (word_we)
    );
endmodule

// File: rtl/dvp_packer_checker.sv
// Property checker for the packer. It observes the ports only and keeps one
// flag of its own that records whether a frame start has been seen.
module dvp_packer_checker #(
    parameter int WORD_W = 32
) (
    input logic              pclk,
    input logic              rst_n,
    input logic [7:0]        cam_data,
    input logic              cam_href,
    input logic              cam_vsync,
    input logic [WORD_W-1:0] word_data,
    input logic              word_we,
    input logic              frame_start
);
    logic fs_seen;

    // Records the first frame-start pulse since reset.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            fs_seen <= 1'b0;
        end else if (frame_start) begin
            fs_seen <= 1'b1;
        end
    end

    assert_we_single_R3: assert property (@(posedge pclk) disable iff (!rst_n)
        word_we |=> !word_we);

    assert_we_after_line_R5: assert property (@(posedge pclk) disable iff (!rst_n)
        word_we |-> ($past(cam_href) || $past(cam_href, 2)));

    assert_no_vsync_capture_R7: assert property (@(posedge pclk) disable iff (!rst_n)
        word_we |-> !$past(cam_vsync, 2));

    assert_no_write_unarmed_R8: assert property (@(posedge pclk) disable iff (!rst_n)
        word_we |-> fs_seen);

    assert_fs_pulse_R9: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_fs_edge_R9: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_start |-> (!$past(cam_vsync) && $past(cam_vsync, 2)));

    assert_hold_R10: assert property (@(posedge pclk) disable iff (!rst_n)
        !word_we |-> $stable(word_data));
endmodule

bind dvp_rgb565_packer dvp_packer_checker #(
    .WORD_W (WORD_W)
) u_chk (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .cam_data    (cam_data),
    .cam_href    (cam_href),
    .cam_vsync   (cam_vsync),
    .word_data   (word_data),
    .word_we     (word_we),
    .frame_start (frame_start)
);

// File: tb/dvp_rgb565_packer_tb.sv
`timescale 1ns/1ps
module dvp_rgb565_packer_tb;
    localparam int W   = 32;
    localparam int PPW = W / 16;

    logic         pclk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   cam_data = '0;
    logic         cam_href = 1'b0;
    logic         cam_vsync = 1'b1;
    logic [W-1:0] word_data;
    logic         word_we;
    logic         frame_start;

    int n_checks = 0;
    int n_fails  = 0;
    int n_wr     = 0;
    int n_fs     = 0;
    logic [W-1:0] last_word = '0;
    logic [7:0]   line_q[$];
    bit           done = 0;

    always #10 pclk = !pclk;

    dvp_rgb565_packer #(.WORD_W(W)) u_dut (
        .pclk(pclk), .rst_n(rst_n), .cam_data(cam_data), .cam_href(cam_href),
        .cam_vsync(cam_vsync), .word_data(word_data), .word_we(word_we),
        .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: integers, flags and a pixel queue.
    bit           m_prev_v, m_rise, m_armed, m_have_hi, cmp_on;
    logic [7:0]   m_hi;
    logic [15:0]  pq[$];
    logic         exp_we, exp_fs;
    logic [W-1:0] exp_data;

    function automatic void m_emit();
        exp_data = '0;
        for (int i = 0; i < pq.size(); i++) exp_data[i*16 +: 16] = pq[i];
        pq.delete();
        exp_we = 1'b1;
    endfunction

    always @(posedge pclk) begin
        if (!rst_n) begin
            m_prev_v = 1; m_rise = 0; m_armed = 0; m_have_hi = 0;
            pq.delete(); exp_we = 0; exp_fs = 0; exp_data = '0; cmp_on = 1;
        end else begin
            bit active;
            bit fall;
            exp_we = 0;
            active = m_armed && cam_href && !cam_vsync;
            fall   = m_prev_v && !cam_vsync && m_rise;
            exp_fs = fall;
            if (active) begin
                if (m_have_hi) begin
                    pq.push_back({m_hi, cam_data});
                    m_have_hi = 0;
                    if (pq.size() == PPW) m_emit();
                end else begin
                    m_hi = cam_data;
                    m_have_hi = 1;
                end
            end else begin
                m_have_hi = 0;
                if (pq.size() > 0) m_emit();
            end
            if (cam_vsync && !m_prev_v) m_rise = 1;
            if (fall) m_armed = 1;
            m_prev_v = cam_vsync;
        end
    end

    // Per-clock comparison, away from the sampling edge.
    always @(negedge pclk) begin
        if (cmp_on && !done) begin
            chk(word_we === exp_we, "R3 strobe", 64'(word_we), 64'(exp_we));
            chk(frame_start === exp_fs, "R9 frame_start", 64'(frame_start), 64'(exp_fs));
            chk(word_data === exp_data, "R2 word_data", 64'(word_data), 64'(exp_data));
            if (word_we) begin n_wr++; last_word = word_data; end
            if (frame_start) n_fs++;
        end
    end

    task automatic cyc(input logic h, input logic v, input logic [7:0] d);
        @(negedge pclk);
        cam_href = h; cam_vsync = v; cam_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'($urandom));
    endtask

    task automatic send_line();
        foreach (line_q[i]) cyc(1'b1, 1'b0, line_q[i]);
        line_q.delete();
        idle(3);
    endtask

    task automatic vpulse();
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 8'($urandom));
        idle(3);
    endtask

    task automatic settle();
        @(negedge pclk); #5;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        summary();
    end

    initial begin
        int w0;
        repeat (3) @(negedge pclk);
        settle();
        chk(word_data === '0 && word_we === 0 && frame_start === 0, "R10 reset state",
            64'(word_data), 64'd0);
        @(negedge pclk); rst_n = 1'b1;
        // Sync high at release, then falls: not a complete pulse.
        cyc(1'b0, 1'b1, 8'h00); cyc(1'b0, 1'b1, 8'h00); idle(2);
        line_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        send_line();
        settle();
        chk(n_wr == 0 && n_fs == 0, "R8 no capture before full pulse", 64'(n_wr), 64'd0);
        vpulse();
        settle();
        chk(n_fs == 1, "R9 first frame start", 64'(n_fs), 64'd1);
        line_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        send_line();
        settle();
        chk(last_word == 32'h5678_1234, "R1 R2 byte and pixel order", 64'(last_word), 64'h5678_1234);
        // Garbage while href low.
        w0 = n_wr;
        idle(6);
        settle();
        chk(n_wr == w0, "R4 href low ignored", 64'(n_wr), 64'(w0));
        line_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        send_line();
        settle();
        chk(last_word == 32'h0000_5566, "R5 partial flush zero padded", 64'(last_word), 64'h5566);
        chk(n_wr == w0 + 2, "R5 full word plus flush", 64'(n_wr), 64'(w0 + 2));
        line_q = '{8'h77, 8'h88, 8'h99};
        send_line();
        settle();
        chk(last_word == 32'h0000_7788, "R5 dangling byte dropped", 64'(last_word), 64'h7788);
        line_q = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        send_line();
        settle();
        chk(last_word == 32'hC3D4_A1B2, "R6 new line restarts phase", 64'(last_word), 64'hC3D4A1B2);
        // Sync rises while the line is open.
        w0 = n_wr;
        foreach (line_q[i]) ;
        cyc(1'b1, 1'b0, 8'h01); cyc(1'b1, 1'b0, 8'h02); cyc(1'b1, 1'b0, 8'h03);
        cyc(1'b1, 1'b0, 8'h04); cyc(1'b1, 1'b0, 8'h05); cyc(1'b1, 1'b0, 8'h06);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 8'hE0 + 8'(i));
        settle();
        chk(n_wr == w0 + 2, "R7 flush on sync, bytes ignored", 64'(n_wr), 64'(w0 + 2));
        chk(last_word == 32'h0000_0506, "R7 flush content", 64'(last_word), 64'h0506);
        idle(3);
        settle();
        chk(n_fs == 2, "R9 frame start after sync", 64'(n_fs), 64'd2);
        // Random frames, checked every clock against the model.
        for (int f = 0; f < 20; f++) begin
            for (int l = 0; l < 8; l++) begin
                int len;
                len = 1 + int'($urandom_range(0, 21));
                for (int b = 0; b < len; b++) line_q.push_back(8'($urandom));
                send_line();
            end
            vpulse();
        end
        idle(4);
        settle();
        chk(n_fs == 22, "R9 frame start count", 64'(n_fs), 64'd22);
        done = 1;
        summary();
    end
endmodule